// File: doc/BRIEF.md
# Compressed Instruction Expander

This block turns one 16-bit compressed RV32 instruction into the 32-bit base-integer instruction that does the same work. It covers all three compressed quadrants: the stack-relative and register-relative word loads and stores, the immediate arithmetic forms, the shifts, the two-register ALU operations, the unconditional jumps, the branches on zero, register moves, indirect jumps and the breakpoint. Reserved or unsupported encodings raise an illegal flag. The floating-point compressed loads and stores and the forms that only exist on 64- or 128-bit machines are among them.

The block sits between fetch and decode as a one-entry pipeline slice with valid/ready handshakes on both sides. An input halfword is taken on a rising clock edge when `in_valid` and `in_ready` are both high. Its expansion shows up on the output one cycle later. `in_ready` is high whenever the output slot is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output holds steady and no new input is taken. A halfword whose two low bits are `11` is not compressed. It is passed through zero-extended, with the compressed indicator low.

Top module: `rvc_expander`

## Requirements
- R1: A halfword accepted on an edge (`in_valid` and `in_ready` both high) appears on the outputs with `out_valid` high after that edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_word`, `out_illegal` and `out_compressed` do not change.
- R2: While `rst_n` is low, `out_valid` is 0. The first cycle after reset has `in_ready` at 1.
- R3: An input with bits [1:0] = `11` gives `out_word = {16'h0000, in_half}`, `out_compressed = 0` and `out_illegal = 0`.
- R4: Any illegal input gives `out_illegal = 1`, `out_word = 0` and `out_compressed = 1`. The following are illegal:
  - the all-zero halfword;
  - quadrant 00 with funct3 (bits [15:13]) other than 000, 010 or 110;
  - quadrant 10 with funct3 other than 000, 010, 100 or 110.
- R5: Quadrant 00 expands as follows:
  - funct3 000 becomes ADDI rd', x2, nzuimm. Bits [12:11] carry imm[5:4], [10:7] carry imm[9:6], [6] carries imm[2] and [5] carries imm[3]. A zero immediate is illegal.
  - funct3 010 becomes LW rd', off(rs1').
  - funct3 110 becomes SW rs2', off(rs1'). For both, off[5:3] comes from bits [12:10], off[2] from [6] and off[6] from [5].
- R6: A 3-bit register field (rs1'/rd' in bits [9:7], rd'/rs2' in bits [4:2]) names the register x(8 + field).
- R7: Quadrant 01, funct3 000 and 010, take a sign-extended 6-bit immediate {bit 12, bits [6:2]}:
  - funct3 000 becomes ADDI rd, rd, imm. With rd (bits [11:7]) nonzero and a zero immediate it is illegal. The all-zero-field word 0x0001 gives ADDI x0, x0, 0.
  - funct3 010 becomes ADDI rd, x0, imm. It is illegal when rd = 0.
- R8: Quadrant 01, funct3 011, has two forms:
  - With rd = 2 it becomes ADDI x2, x2, imm. The immediate is sign-extended, with imm[9] from bit 12, imm[4] from [6], imm[6] from [5], imm[8:7] from [4:3] and imm[5] from [2]. A zero immediate is illegal.
  - With any other rd it becomes LUI rd, imm. The 20-bit field is {bit 12, bits [6:2]} sign-extended. rd = 0 or a zero immediate is illegal.
- R9: Quadrant 01, funct3 001, becomes JAL x1, and funct3 101 becomes JAL x0. The offset is sign-extended and taken from bits [12:2] in the order [11|4|9:8|10|6|7|3:1|5].
- R10: Quadrant 01, funct3 110, becomes BEQ rs1', x0, off, and funct3 111 becomes BNE rs1', x0, off. The offset is sign-extended, with off[8] from bit 12, [4:3] from [11:10], [7:6] from [6:5], [2:1] from [4:3] and [5] from [2].
- R11: Quadrant 01, funct3 100, selects on bits [11:10]:
  - 00 becomes SRLI rs1', rs1', shamt and 01 becomes SRAI rs1', rs1', shamt. shamt comes from bits [6:2], and bit 12 set is illegal.
  - 10 becomes ANDI rs1', rs1', imm6.
  - 11 with bit 12 clear becomes SUB, XOR, OR or AND rd', rd', rs2', for bits [6:5] = 00, 01, 10, 11. With bit 12 set it is illegal.
- R12: Quadrant 10 has three forms:
  - funct3 000 becomes SLLI rd, rd, shamt. Bit 12 set or rd = 0 is illegal.
  - funct3 010 becomes LW rd, off(x2), with off[5] from bit 12, [4:2] from [6:4] and [7:6] from [3:2].
  - funct3 110 becomes SW rs2, off(x2), with rs2 from bits [6:2], off[5:2] from [12:9] and [7:6] from [8:7].
- R13: Quadrant 10, funct3 100, decodes on bit 12, rd = bits [11:7] and rs2 = bits [6:2]:
  - Bit 12 clear: rs2 = 0 gives JALR x0, 0(rd), and otherwise ADD rd, x0, rs2.
  - Bit 12 set: rd = rs2 = 0 gives EBREAK (0x00100073), rs2 = 0 gives JALR x1, 0(rd), and otherwise ADD rd, rd, rs2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input halfword is present |
| in_ready | output | 1 | Block accepts an input this cycle |
| in_half | input | 16 | Instruction halfword |
| out_valid | output | 1 | Output slot holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_word | output | 32 | Expanded instruction, zero when illegal |
| out_illegal | output | 1 | Input encoding is reserved or unsupported |
| out_compressed | output | 1 | Input was a compressed halfword |

## Verification
The expansion is driven with immediates that set only one scrambled bit, all bits, or only the sign bit. These separate a misplaced immediate bit from a wrong sign extension. Register fields at 000 and 111 and mixed values check the x8 offset. Each overlapping encoding is tried on both sides of its selector: rd = 2 against other rd, rs2 = 0 against nonzero, bit 12 set and clear. Each reserved value (zero immediate, rd = 0, shift bit 5, unsupported funct3) is shown to raise the flag and clear the word. A stalled consumer then shows that the output holds and that input is refused.

// File: rtl/rvc_pkg.sv
package rvc_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 32;
  localparam int REG_W  = 5;

  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [WORD_W-1:0] WORD_BREAK = 32'h0010_0073;

  localparam logic [REG_W-1:0] REG_ZERO = 5'd0;
  localparam logic [REG_W-1:0] REG_LINK = 5'd1;
  localparam logic [REG_W-1:0] REG_SP   = 5'd2;

  // 3-bit short register field -> x8..x15
  function automatic logic [REG_W-1:0] short_reg(input logic [2:0] f);
    return {2'b01, f};
  endfunction

  function automatic logic [WORD_W-1:0] enc_i(input logic [11:0] imm,
      input logic [REG_W-1:0] rs1, input logic [2:0] f3,
      input logic [REG_W-1:0] rd, input logic [6:0] opc);
    return {imm, rs1, f3, rd, opc};
  endfunction

  function automatic logic [WORD_W-1:0] enc_s(input logic [11:0] imm,
      input logic [REG_W-1:0] rs2, input logic [REG_W-1:0] rs1,
      input logic [2:0] f3);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], OPC_STORE};
  endfunction

  function automatic logic [WORD_W-1:0] enc_b(input logic [12:1] off,
      input logic [REG_W-1:0] rs2, input logic [REG_W-1:0] rs1,
      input logic [2:0] f3);
    return {off[12], off[10:5], rs2, rs1, f3, off[4:1], off[11], OPC_BRANCH};
  endfunction

  function automatic logic [WORD_W-1:0] enc_u(input logic [19:0] imm,
      input logic [REG_W-1:0] rd);
    return {imm, rd, OPC_LUI};
  endfunction

  function automatic logic [WORD_W-1:0] enc_j(input logic [20:1] off,
      input logic [REG_W-1:0] rd);
    return {off[20], off[10:1], off[11], off[19:12], rd, OPC_JAL};
  endfunction

  function automatic logic [WORD_W-1:0] enc_r(input logic [6:0] f7,
      input logic [REG_W-1:0] rs2, input logic [REG_W-1:0] rs1,
      input logic [2:0] f3, input logic [REG_W-1:0] rd);
    return {f7, rs2, rs1, f3, rd, OPC_OP};
  endfunction
endpackage

// File: rtl/rvc_q0_dec.sv
module rvc_q0_dec import rvc_pkg::*; (
  input  logic [15:2]       hw,
  output logic [WORD_W-1:0] word,
  output logic              illegal
);
  logic [9:0] spn_imm;
  logic [6:0] mem_off;
  logic [REG_W-1:0] base_r, low_r;

  assign spn_imm = {hw[10:7], hw[12:11], hw[5], hw[6], 2'b00};
  assign mem_off = {hw[5], hw[12:10], hw[6], 2'b00};
  assign base_r  = short_reg(hw[9:7]);
  assign low_r   = short_reg(hw[4:2]);

  always_comb begin
    word    = '0;
    illegal = 1'b0;
    unique case (hw[15:13])
      3'b000: begin
        illegal = (spn_imm == '0);
        word    = enc_i({2'b00, spn_imm}, REG_SP, 3'b000, low_r, OPC_OPIMM);
      end
      3'b010: word = enc_i({5'b0, mem_off}, base_r, 3'b010, low_r, OPC_LOAD);
      3'b110: word = enc_s({5'b0, mem_off}, low_r, base_r, 3'b010);
      default: illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/rvc_q1_dec.sv
module rvc_q1_dec import rvc_pkg::*; (
  input  logic [15:2]       hw,
  output logic [WORD_W-1:0] word,
  output logic              illegal
);
  logic [5:0]       imm6;
  logic [11:0]      imm12;
  logic [9:0]       sp_imm;
  logic [20:1]      jmp_off;
  logic [12:1]      br_off;
  logic [REG_W-1:0] rd, rs_hi, rs_lo;
  logic [6:0]       alu_f7;
  logic [2:0]       alu_f3;

  assign imm6    = {hw[12], hw[6:2]};
  assign imm12   = {{6{hw[12]}}, imm6};
  assign sp_imm  = {hw[12], hw[4:3], hw[5], hw[2], hw[6], 4'b0000};
  assign jmp_off = {{9{hw[12]}}, hw[12], hw[8], hw[10:9], hw[6], hw[7],
                    hw[2], hw[11], hw[5:3]};
  assign br_off  = {{4{hw[12]}}, hw[12], hw[6:5], hw[2], hw[11:10], hw[4:3]};
  assign rd      = hw[11:7];
  assign rs_hi   = short_reg(hw[9:7]);
  assign rs_lo   = short_reg(hw[4:2]);

  always_comb begin
    unique case (hw[6:5])
      2'b00:   begin alu_f7 = 7'b0100000; alu_f3 = 3'b000; end
      2'b01:   begin alu_f7 = 7'b0000000; alu_f3 = 3'b100; end
      2'b10:   begin alu_f7 = 7'b0000000; alu_f3 = 3'b110; end
      default: begin alu_f7 = 7'b0000000; alu_f3 = 3'b111; end
    endcase
  end

  always_comb begin
    word    = '0;
    illegal = 1'b0;
    unique case (hw[15:13])
      3'b000: begin
        illegal = (imm6 == '0) && (rd != REG_ZERO);
        word    = enc_i(imm12, rd, 3'b000, rd, OPC_OPIMM);
      end
      3'b001: word = enc_j(jmp_off, REG_LINK);
      3'b010: begin
        illegal = (rd == REG_ZERO);
        word    = enc_i(imm12, REG_ZERO, 3'b000, rd, OPC_OPIMM);
      end
      3'b011: begin
        if (rd == REG_SP) begin
          illegal = (sp_imm == '0);
          word    = enc_i({{2{hw[12]}}, sp_imm}, REG_SP, 3'b000, REG_SP, OPC_OPIMM);
        end else begin
          illegal = (rd == REG_ZERO) || (imm6 == '0);
          word    = enc_u({{14{hw[12]}}, imm6}, rd);
        end
      end
      3'b100: begin
        unique case (hw[11:10])
          2'b00: begin
            illegal = hw[12];
            word    = enc_i({7'b0000000, hw[6:2]}, rs_hi, 3'b101, rs_hi, OPC_OPIMM);
          end
          2'b01: begin
            illegal = hw[12];
            word    = enc_i({7'b0100000, hw[6:2]}, rs_hi, 3'b101, rs_hi, OPC_OPIMM);
          end
          2'b10: word = enc_i(imm12, rs_hi, 3'b111, rs_hi, OPC_OPIMM);
          default: begin
            illegal = hw[12];
            word    = enc_r(alu_f7, rs_lo, rs_hi, alu_f3, rs_hi);
          end
        endcase
      end
      3'b101: word = enc_j(jmp_off, REG_ZERO);
      3'b110: word = enc_b(br_off, REG_ZERO, rs_hi, 3'b000);
      default: word = enc_b(br_off, REG_ZERO, rs_hi, 3'b001);
    endcase
  end
endmodule

// File: rtl/rvc_q2_dec.sv
module rvc_q2_dec import rvc_pkg::*; (
  input  logic [15:2]       hw,
  output logic [WORD_W-1:0] word,
  output logic              illegal
);
  logic [REG_W-1:0] rd, rs2;
  logic [7:0]       ld_off, st_off;

  assign rd     = hw[11:7];
  assign rs2    = hw[6:2];
  assign ld_off = {hw[3:2], hw[12], hw[6:4], 2'b00};
  assign st_off = {hw[8:7], hw[12:9], 2'b00};

  always_comb begin
    word    = '0;
    illegal = 1'b0;
    unique case (hw[15:13])
      3'b000: begin
        illegal = hw[12] || (rd == REG_ZERO);
        word    = enc_i({7'b0000000, hw[6:2]}, rd, 3'b001, rd, OPC_OPIMM);
      end
      3'b010: word = enc_i({4'b0000, ld_off}, REG_SP, 3'b010, rd, OPC_LOAD);
      3'b100: begin
        if (!hw[12]) begin
          if (rs2 == REG_ZERO) word = enc_i(12'h000, rd, 3'b000, REG_ZERO, OPC_JALR);
          else                 word = enc_r(7'b0, rs2, REG_ZERO, 3'b000, rd);
        end else begin
          if ((rd == REG_ZERO) && (rs2 == REG_ZERO)) word = WORD_BREAK;
          else if (rs2 == REG_ZERO) word = enc_i(12'h000, rd, 3'b000, REG_LINK, OPC_JALR);
          else                      word = enc_r(7'b0, rs2, rd, 3'b000, rd);
        end
      end
      3'b110: word = enc_s({4'b0000, st_off}, rs2, REG_SP, 3'b010);
      default: illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/rvc_expander.sv
module rvc_expander import rvc_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [HALF_W-1:0] in_half,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              out_illegal,
  output logic              out_compressed
);
  localparam int NQ = 3;

  logic [WORD_W-1:0] q_word [NQ];
  logic [NQ-1:0]     q_ill;
  logic [WORD_W-1:0] nx_word;
  logic              nx_ill, nx_comp;

  rvc_q0_dec u_q0 (.hw(in_half[15:2]), .word(q_word[0]), .illegal(q_ill[0]));
  rvc_q1_dec u_q1 (.hw(in_half[15:2]), .word(q_word[1]), .illegal(q_ill[1]));
  rvc_q2_dec u_q2 (.hw(in_half[15:2]), .word(q_word[2]), .illegal(q_ill[2]));

  always_comb begin
    if (in_half[1:0] == 2'b11) begin
      nx_comp = 1'b0;
      nx_ill  = 1'b0;
      nx_word = {{(WORD_W-HALF_W){1'b0}}, in_half};
    end else begin
      nx_comp = 1'b1;
      nx_ill  = q_ill[in_half[1:0]];
      nx_word = nx_ill ? '0 : q_word[in_half[1:0]];
    end
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_word       <= '0;
      out_illegal    <= 1'b0;
      out_compressed <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word       <= nx_word;
        out_illegal    <= nx_ill;
        out_compressed <= nx_comp;
      end
    end
  end
endmodule

// File: rtl/rvc_expander_chk.sv
module rvc_expander_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_word,
  input logic        out_illegal,
  input logic        out_compressed
);
  // R1: accepted input shows up next cycle
  a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R1: stalled output is held
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word)
      && $stable(out_illegal) && $stable(out_compressed));

  // R3: uncompressed input never flagged, low bits stay 11
  a_r3_pass: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_compressed |-> !out_illegal && out_word[1:0] == 2'b11);

  // R4: illegal result has zero word and came from a compressed halfword
  a_r4_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_word == 32'h0 && out_compressed);

  // R4: legal compressed result carries a base-integer opcode
  a_r4_opcode_set: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_compressed && !out_illegal |->
      out_word[6:0] inside {7'b0000011, 7'b0010011, 7'b0100011, 7'b0110011,
                            7'b0110111, 7'b1100011, 7'b1100111, 7'b1101111,
                            7'b1110011});
endmodule

bind rvc_expander rvc_expander_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
  .out_illegal(out_illegal), .out_compressed(out_compressed)
);

// File: tb/rvc_expander_tb.sv
`timescale 1ns/1ps
module rvc_expander_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_half = 16'h0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_word;
  logic        out_illegal;
  logic        out_compressed;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rvc_expander u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_half(in_half), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .out_illegal(out_illegal),
    .out_compressed(out_compressed)
  );

  // {halfword, expected word, illegal, compressed, requirement number}
  localparam int NV = 43;
  localparam logic [53:0] VEC [NV] = '{
    {16'h0001, 32'h00000013, 1'b0, 1'b1, 4'd7},   // R7 nop
    {16'h0085, 32'h00108093, 1'b0, 1'b1, 4'd7},   // R7 addi +1
    {16'h10FD, 32'hFFF08093, 1'b0, 1'b1, 4'd7},   // R7 addi -1
    {16'h0081, 32'h00000000, 1'b1, 1'b1, 4'd7},   // R7 addi zero imm
    {16'h4515, 32'h00500513, 1'b0, 1'b1, 4'd7},   // R7 li
    {16'h4015, 32'h00000000, 1'b1, 1'b1, 4'd7},   // R7 li rd=0
    {16'h6285, 32'h000012B7, 1'b0, 1'b1, 4'd8},   // R8 lui +1
    {16'h72FD, 32'hFFFFF2B7, 1'b0, 1'b1, 4'd8},   // R8 lui -1
    {16'h6281, 32'h00000000, 1'b1, 1'b1, 4'd8},   // R8 lui zero
    {16'h6141, 32'h01010113, 1'b0, 1'b1, 4'd8},   // R8 sp +16
    {16'h7101, 32'hE0010113, 1'b0, 1'b1, 4'd8},   // R8 sp -512
    {16'h6101, 32'h00000000, 1'b1, 1'b1, 4'd8},   // R8 sp zero
    {16'h0040, 32'h00410413, 1'b0, 1'b1, 4'd5},   // R5 spn x8,4
    {16'h1FFC, 32'h3FC10793, 1'b0, 1'b1, 4'd5},   // R5 spn x15,1020
    {16'h0000, 32'h00000000, 1'b1, 1'b1, 4'd4},   // R4 all zero
    {16'h4144, 32'h00452483, 1'b0, 1'b1, 4'd6},   // R6 lw x9,4(x10)
    {16'hC22C, 32'h04B62023, 1'b0, 1'b1, 4'd6},   // R6 sw x11,64(x12)
    {16'h2000, 32'h00000000, 1'b1, 1'b1, 4'd4},   // R4 q0 funct3 001
    {16'hA009, 32'h0020006F, 1'b0, 1'b1, 4'd9},   // R9 j +2
    {16'h3FFD, 32'hFFFFF0EF, 1'b0, 1'b1, 4'd9},   // R9 jal -2
    {16'h3001, 32'h801FF0EF, 1'b0, 1'b1, 4'd9},   // R9 jal -2048
    {16'hC401, 32'h00040463, 1'b0, 1'b1, 4'd10},  // R10 beqz +8
    {16'hF381, 32'hF00790E3, 1'b0, 1'b1, 4'd10},  // R10 bnez -256
    {16'h800D, 32'h00345413, 1'b0, 1'b1, 4'd11},  // R11 srli
    {16'h84FD, 32'h41F4D493, 1'b0, 1'b1, 4'd11},  // R11 srai 31
    {16'h900D, 32'h00000000, 1'b1, 1'b1, 4'd11},  // R11 shamt bit5
    {16'h997D, 32'hFFF57513, 1'b0, 1'b1, 4'd11},  // R11 andi -1
    {16'h8C05, 32'h40940433, 1'b0, 1'b1, 4'd11},  // R11 sub
    {16'h8EF9, 32'h00E6F6B3, 1'b0, 1'b1, 4'd11},  // R11 and
    {16'h9C05, 32'h00000000, 1'b1, 1'b1, 4'd11},  // R11 bit12 alu
    {16'h0092, 32'h00409093, 1'b0, 1'b1, 4'd12},  // R12 slli
    {16'h0012, 32'h00000000, 1'b1, 1'b1, 4'd12},  // R12 slli rd=0
    {16'h1092, 32'h00000000, 1'b1, 1'b1, 4'd12},  // R12 slli bit5
    {16'h4092, 32'h00412083, 1'b0, 1'b1, 4'd12},  // R12 lwsp
    {16'hDF86, 32'h0E112E23, 1'b0, 1'b1, 4'd12},  // R12 swsp 252
    {16'h8082, 32'h00008067, 1'b0, 1'b1, 4'd13},  // R13 jr
    {16'h852E, 32'h00B00533, 1'b0, 1'b1, 4'd13},  // R13 mv
    {16'h9002, 32'h00100073, 1'b0, 1'b1, 4'd13},  // R13 ebreak
    {16'h9282, 32'h000280E7, 1'b0, 1'b1, 4'd13},  // R13 jalr
    {16'h952E, 32'h00B50533, 1'b0, 1'b1, 4'd13},  // R13 add
    {16'h2002, 32'h00000000, 1'b1, 1'b1, 4'd4},   // R4 q2 funct3 001
    {16'h0013, 32'h00000013, 1'b0, 1'b0, 4'd3},   // R3 pass
    {16'h8000, 32'h00000000, 1'b1, 1'b1, 4'd4}    // R4 q0 funct3 100
  };

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 32'h0, 32'h1);
      finish_run();
    end
  end

  initial begin
    // R2: reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R2 valid in reset", {31'b0, out_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R2 ready after reset", {31'b0, in_ready}, 32'h1);
    chk(out_valid == 1'b0, "R2 idle after reset", {31'b0, out_valid}, 32'h0);

    // Vector walk, consumer always ready
    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1;
      in_half  = VEC[i][53:38];
      @(negedge clk);
      chk(out_valid && out_word == VEC[i][37:6] && out_illegal == VEC[i][5]
          && out_compressed == VEC[i][4],
          $sformatf("R%0d vec %0d half=%04h ill=%0b comp=%0b", VEC[i][3:0], i,
                    VEC[i][53:38], out_illegal, out_compressed),
          out_word, VEC[i][37:6]);
    end

    // R3: all-ones halfword zero-extended
    in_half = 16'hFFFF;
    @(negedge clk);
    chk(out_word == 32'h0000FFFF && !out_compressed && !out_illegal,
        "R3 pass 0xFFFF", out_word, 32'h0000FFFF);

    // R1: back-pressure holds output and blocks input
    in_half = 16'h0001;
    @(negedge clk);
    out_ready = 1'b0;
    in_half   = 16'h4515;
    #0.1;
    chk(in_ready == 1'b0, "R1 ready low when stalled", {31'b0, in_ready}, 32'h0);
    @(negedge clk);
    chk(out_valid && out_word == 32'h00000013, "R1 held word", out_word, 32'h00000013);
    @(negedge clk);
    chk(out_valid && out_word == 32'h00000013, "R1 still held", out_word, 32'h00000013);
    out_ready = 1'b1;
    #0.1;
    chk(in_ready == 1'b1, "R1 ready when drained", {31'b0, in_ready}, 32'h1);
    @(negedge clk);
    chk(out_valid && out_word == 32'h00500513, "R1 next after release", out_word, 32'h00500513);
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 empty after drain", {31'b0, out_valid}, 32'h0);

    // R2: reset during traffic
    in_valid = 1'b1;
    in_half  = 16'h0085;
    @(negedge clk);
    rst_n = 1'b0;
    #0.1;
    chk(out_valid == 1'b0, "R2 reset clears valid", {31'b0, out_valid}, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule